// File: doc/BRIEF.md
# Serial Receive Error and Interrupt Unit

This unit keeps the receive-side error status and the interrupt state of an asynchronous serial port. The receiver reports events as single-cycle strobes: a parity error, a framing error, an overrun, or a completed character. The transmit path reports a FIFO trigger. The unit holds the parity, framing and overrun conditions as sticky flags. Each flag can only be raised while its own detection enable is set and the receiver is enabled.

Software reaches the unit through a simple single-cycle write port with four locations:

| `wr_addr_i` | Location |
|---|---|
| 0 | Detection-control register |
| 1 | Write-only set/clear register (receiver enable and flag clears) |
| 2 | Interrupt enable register |
| 3 | Write-one-to-clear interrupt request register |

The status word on `state_o` is always visible. Three interrupt lines go to the interrupt controller. The serial shifters and the FIFOs sit outside this unit.

Top module: `uart_rx_err_irq`

## Requirements
- R1: `state_o` shows the sticky parity flag at bit 16, the framing flag at bit 17, the overrun flag at bit 19 and the receiver enable at bit 0, and all other bits read 0. A flag stays set until it is cleared.
- R2: A write to location 1 clears the parity flag with bit 2, the framing flag with bit 3 and the overrun flag with bit 5. A flag whose clear bit is 0 keeps its value.
- R3: A write to location 1 with bit 1 set turns the receiver enable on. With bit 0 set (and bit 1 clear) it turns the receiver enable off. With both bits set, the enable turns on.
- R4: Location 0 holds the detection enables: framing at bit 17, overrun at bit 19 and parity at bit 20. An error strobe sets its flag only while its enable is 1.
- R5: An overrun strobe sets only the overrun flag and does not raise parity or framing. A character strobe in the same cycle still raises the receive request.
- R6: Location 2 holds the interrupt enables: transmit at bit 0, receive at bit 1 and error at bit 2. `irq_tx_o` is high when the transmit request and its enable are both 1. `irq_rx_o` is high when the receive request and its enable are both 1.
- R7: The request bits are set as follows:
  - transmit (bit 0) is set by a transmit trigger;
  - receive (bit 1) is set by a character strobe;
  - error (bit 2) is set by any flag-setting event.

  Writing a 1 to location 3 clears the matching request bit. Writing a 0 leaves it unchanged.
- R8: `irq_err_o` is high while the error interrupt is enabled and either a flag is set whose detection enable is 1, or the error request is pending.
- R9: If a set event and a clear write hit the same flag or request bit in the same cycle, the bit ends up set.
- R10: While the receiver enable is 0, character and error strobes set no flag and no request.
- R11: After reset all flags, requests, enables and the receiver enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select (0 control, 1 set/clear, 2 interrupt enable, 3 request clear) |
| wr_data_i | input | 32 | Write data |
| par_err_i | input | 1 | Parity error strobe from the receiver |
| frm_err_i | input | 1 | Framing error strobe from the receiver |
| ovr_err_i | input | 1 | Overrun strobe from the receiver |
| rx_char_i | input | 1 | Character received strobe |
| tx_trig_i | input | 1 | Transmit FIFO trigger strobe |
| state_o | output | 32 | Status word: flags and receiver enable |
| irq_tx_o | output | 1 | Transmit interrupt line |
| irq_rx_o | output | 1 | Receive interrupt line |
| irq_err_o | output | 1 | Error interrupt line |

## Verification
The assertions check, on every cycle:
- that a set beats a clear in the same cycle;
- that a clear without a set empties the bit;
- that an untouched flag or request holds its value;
- that a flag cannot rise while its detection or the receiver is off.

Only the bench's scenarios can show the bit positions of the write fields and status fields, the way the enable registers gate the three lines, and the both-bits case of the receiver enable. The bench covers these by sweeping every detection-enable setting against every strobe combination, and every interrupt-enable setting against pending requests.

// File: rtl/ue_pkg.sv
package ue_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_SETCLR = 2'd1,
    ADDR_IEN    = 2'd2,
    ADDR_IRQCLR = 2'd3
  } ue_addr_e;

  localparam int NUM_ERR = 3;  // 0 parity, 1 framing, 2 overrun
  localparam int NUM_IRQ = 3;  // 0 tx, 1 rx, 2 err

  // state word positions
  localparam int ST_RXEN = 0;
  localparam int ST_PE   = 16;
  localparam int ST_FE   = 17;
  localparam int ST_ROE  = 19;

  // set/clear word positions
  localparam int SC_RXEN_CLR = 0;
  localparam int SC_RXEN_SET = 1;
  localparam int SC_PE_CLR   = 2;
  localparam int SC_FE_CLR   = 3;
  localparam int SC_ROE_CLR  = 5;

  // control word positions
  localparam int CT_FEN  = 17;
  localparam int CT_ROEN = 19;
  localparam int CT_PEN  = 20;
endpackage

// File: rtl/ue_sticky_bit.sv
module ue_sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o); // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o); // R2
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> (q_o == $past(q_o))); // R1
endmodule

// File: rtl/ue_irq_gate.sv
module ue_irq_gate #(
  parameter int NUM_ERR = 3
) (
  input  logic               ien_tx_i,
  input  logic               ien_rx_i,
  input  logic               ien_err_i,
  input  logic               req_tx_i,
  input  logic               req_rx_i,
  input  logic               req_err_i,
  input  logic [NUM_ERR-1:0] flag_i,
  input  logic [NUM_ERR-1:0] det_en_i,
  output logic               irq_tx_o,
  output logic               irq_rx_o,
  output logic               irq_err_o
);
  logic any_enabled_flag;

  assign any_enabled_flag = |(flag_i & det_en_i);
  assign irq_tx_o  = ien_tx_i & req_tx_i;
  assign irq_rx_o  = ien_rx_i & req_rx_i;
  assign irq_err_o = ien_err_i & (req_err_i | any_enabled_flag);
endmodule

// File: rtl/uart_rx_err_irq.sv
module uart_rx_err_irq
  import ue_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          par_err_i,
  input  logic          frm_err_i,
  input  logic          ovr_err_i,
  input  logic          rx_char_i,
  input  logic          tx_trig_i,
  output logic [DW-1:0] state_o,
  output logic          irq_tx_o,
  output logic          irq_rx_o,
  output logic          irq_err_o
);
  localparam int CLR_POS [NUM_ERR] = '{SC_PE_CLR, SC_FE_CLR, SC_ROE_CLR};

  logic wr_ctrl, wr_setclr, wr_ien, wr_irqclr;
  logic               rx_en_q;
  logic [NUM_ERR-1:0] det_en_q;
  logic [NUM_IRQ-1:0] ien_q;
  logic [NUM_ERR-1:0] strobe, set_ev, clr_ev, flag;
  logic [NUM_IRQ-1:0] req_set, req_clr, req;
  logic               unused_wr_bits;

  assign wr_ctrl   = wr_en_i && (ue_addr_e'(wr_addr_i) == ADDR_CTRL);
  assign wr_setclr = wr_en_i && (ue_addr_e'(wr_addr_i) == ADDR_SETCLR);
  assign wr_ien    = wr_en_i && (ue_addr_e'(wr_addr_i) == ADDR_IEN);
  assign wr_irqclr = wr_en_i && (ue_addr_e'(wr_addr_i) == ADDR_IRQCLR);
  assign unused_wr_bits = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q  <= 1'b0;
      det_en_q <= '0;
      ien_q    <= '0;
    end else begin
      if (wr_setclr) begin
        if (wr_data_i[SC_RXEN_SET])      rx_en_q <= 1'b1;
        else if (wr_data_i[SC_RXEN_CLR]) rx_en_q <= 1'b0;
      end
      if (wr_ctrl)
        det_en_q <= {wr_data_i[CT_ROEN], wr_data_i[CT_FEN], wr_data_i[CT_PEN]};
      if (wr_ien)
        ien_q <= wr_data_i[NUM_IRQ-1:0];
    end
  end

  // overrun strobe feeds only its own flag; the character itself stays good
  assign strobe = {ovr_err_i, frm_err_i, par_err_i};

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
    assign set_ev[i] = strobe[i] & det_en_q[i] & rx_en_q;
    assign clr_ev[i] = wr_setclr & wr_data_i[CLR_POS[i]];
    ue_sticky_bit i_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_ev[i]),
      .clr_i  (clr_ev[i]),
      .q_o    (flag[i])
    );
  end

  assign req_set = {|set_ev, rx_char_i & rx_en_q, tx_trig_i};

  for (genvar j = 0; j < NUM_IRQ; j++) begin : g_req
    assign req_clr[j] = wr_irqclr & wr_data_i[j];
    ue_sticky_bit i_req (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (req_set[j]),
      .clr_i  (req_clr[j]),
      .q_o    (req[j])
    );
  end

  ue_irq_gate #(.NUM_ERR(NUM_ERR)) i_gate (
    .ien_tx_i  (ien_q[0]),
    .ien_rx_i  (ien_q[1]),
    .ien_err_i (ien_q[2]),
    .req_tx_i  (req[0]),
    .req_rx_i  (req[1]),
    .req_err_i (req[2]),
    .flag_i    (flag),
    .det_en_i  (det_en_q),
    .irq_tx_o  (irq_tx_o),
    .irq_rx_o  (irq_rx_o),
    .irq_err_o (irq_err_o)
  );

  always_comb begin
    state_o          = '0;
    state_o[ST_RXEN] = rx_en_q;
    state_o[ST_PE]   = flag[0];
    state_o[ST_FE]   = flag[1];
    state_o[ST_ROE]  = flag[2];
  end

  AST_PE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag[0] && !(det_en_q[0] && rx_en_q)) |=> !state_o[ST_PE]); // R4
  AST_FE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag[1] && !(det_en_q[1] && rx_en_q)) |=> !state_o[ST_FE]); // R4
  AST_RX_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_q && !req[1]) |=> !req[1]); // R10
  AST_OVR_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_err_i && !par_err_i && !frm_err_i && !flag[0] && !flag[1])
      |=> (!state_o[ST_PE] && !state_o[ST_FE])); // R5
endmodule

// File: tb/test_uart_rx_err_irq.sv
module test_uart_rx_err_irq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        par_err_i = 1'b0, frm_err_i = 1'b0, ovr_err_i = 1'b0;
  logic        rx_char_i = 1'b0, tx_trig_i = 1'b0;
  logic [31:0] state_o;
  logic        irq_tx_o, irq_rx_o, irq_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  bit       m_rxen;
  bit [2:0] m_flag, m_den, m_ien, m_req;

  always #2 clk_i = ~clk_i;

  uart_rx_err_irq i_uart_rx_err_irq (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .par_err_i, .frm_err_i, .ovr_err_i, .rx_char_i, .tx_trig_i,
    .state_o, .irq_tx_o, .irq_rx_o, .irq_err_o
  );

  function automatic logic [34:0] expected();
    logic [31:0] st = '0;
    st[0]  = m_rxen;
    st[16] = m_flag[0];
    st[17] = m_flag[1];
    st[19] = m_flag[2];
    return {m_ien[2] & (m_req[2] | |(m_flag & m_den)),
            m_ien[1] & m_req[1], m_ien[0] & m_req[0], st};
  endfunction

  task automatic check(string tag);
    logic [34:0] exp = expected();
    logic [34:0] act = {irq_err_o, irq_rx_o, irq_tx_o, state_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit we, bit [1:0] a, bit [31:0] d,
                      bit [2:0] err, bit ch, bit tx);
    bit [2:0] sev, clr, rset, rclr;
    @(negedge clk_i);
    wr_en_i = we; wr_addr_i = a; wr_data_i = d;
    {ovr_err_i, frm_err_i, par_err_i} = err;
    rx_char_i = ch; tx_trig_i = tx;
    sev  = err & m_den & {3{m_rxen}};
    clr  = (we && a == 2'd1) ? {d[5], d[3], d[2]} : 3'b0;
    rset = {|sev, ch & m_rxen, tx};
    rclr = (we && a == 2'd3) ? d[2:0] : 3'b0;
    m_flag = sev | (m_flag & ~clr);
    m_req  = rset | (m_req & ~rclr);
    if (we && a == 2'd1) begin
      if (d[1]) m_rxen = 1'b1;
      else if (d[0]) m_rxen = 1'b0;
    end
    if (we && a == 2'd0) m_den = {d[19], d[17], d[20]};
    if (we && a == 2'd2) m_ien = d[2:0];
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0; {ovr_err_i, frm_err_i, par_err_i} = 3'b0;
    rx_char_i = 1'b0; tx_trig_i = 1'b0;
    check(tag);
  endtask

  function automatic bit [31:0] den_word(bit [2:0] e);
    return (32'(e[0]) << 20) | (32'(e[1]) << 17) | (32'(e[2]) << 19);
  endfunction

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1 check("R11 reset");
    // detection and interrupts on, receiver still off
    step("R4 ctrl write", 1, 2'd0, den_word(3'b111), 3'b000, 0, 0);
    step("R6 ien write", 1, 2'd2, 32'h7, 3'b000, 0, 0);
    step("R10 rx off strobes", 0, 2'd0, 0, 3'b111, 1, 0);
    step("R3 rx enable set", 1, 2'd1, 32'h2, 3'b000, 0, 0);
    step("R3 rx enable clear", 1, 2'd1, 32'h1, 3'b000, 0, 0);
    step("R3 both bits set", 1, 2'd1, 32'h3, 3'b000, 0, 0);
    // sweep detection enables against strobe patterns
    for (int e = 0; e < 8; e++) begin
      for (int s = 1; s < 8; s++) begin
        step("R4 den write", 1, 2'd0, den_word(3'(e)), 3'b000, 0, 0);
        step("R2 clear all", 1, 2'd1, 32'h2C | 32'h2, 3'b000, 0, 0);
        step("R7 req clear", 1, 2'd3, 32'h7, 3'b000, 0, 0);
        step("R4 gated strobe", 0, 2'd0, 0, 3'(s), 0, 0);
        step("R1 sticky hold", 0, 2'd0, 0, 3'b000, 0, 0);
        step("R8 err line", 1, 2'd0, den_word(3'b000), 3'b000, 0, 0);
        step("R8 err req clear", 1, 2'd3, 32'h4, 3'b000, 0, 0);
      end
    end
    // individual clears
    step("R4 all det on", 1, 2'd0, den_word(3'b111), 3'b000, 0, 0);
    step("R1 set all", 0, 2'd0, 0, 3'b111, 0, 0);
    step("R2 clear parity", 1, 2'd1, 32'h4 | 32'h2, 3'b000, 0, 0);
    step("R2 clear framing", 1, 2'd1, 32'h8 | 32'h2, 3'b000, 0, 0);
    step("R2 clear overrun", 1, 2'd1, 32'h20 | 32'h2, 3'b000, 0, 0);
    // set beats clear
    step("R9 flag set vs clear", 1, 2'd1, 32'h2E, 3'b111, 0, 0);
    step("R9 req set vs clear", 1, 2'd3, 32'h7, 3'b001, 1, 1);
    step("R2 clear flags", 1, 2'd1, 32'h2E, 3'b000, 0, 0);
    step("R7 clear reqs", 1, 2'd3, 32'h7, 3'b000, 0, 0);
    // overrun alone with a character
    step("R5 overrun with char", 0, 2'd0, 0, 3'b100, 1, 0);
    step("R7 clear rx only", 1, 2'd3, 32'h2, 3'b000, 0, 0);
    step("R7 tx trigger", 0, 2'd0, 0, 3'b000, 0, 1);
    // interrupt enable sweep with all requests pending
    step("R7 set all reqs", 0, 2'd0, 0, 3'b001, 1, 1);
    for (int k = 0; k < 8; k++)
      step("R6 ien sweep", 1, 2'd2, 32'(k), 3'b000, 0, 0);
    step("R7 write zero keeps", 1, 2'd3, 32'h0, 3'b000, 0, 0);
    step("R10 rx off", 1, 2'd1, 32'h1, 3'b000, 0, 0);
    step("R7 clear all", 1, 2'd3, 32'h7, 3'b000, 0, 0);
    step("R10 ignored char", 0, 2'd0, 0, 3'b011, 1, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule